// File: doc/BRIEF.md
# Oversampling UART Receiver with Noise Detection

This block recovers asynchronous serial frames from a single receive line. An external tick runs at sixteen times the bit rate. A two-flop synchronizer brings the line into the clock domain. A falling edge while the receiver is idle starts a frame and restarts the sample counter, so timing errors can only build up within one frame.

Each bit is decided by a 2-of-3 vote on three mid-bit samples. If those three samples do not all agree, the frame is marked noisy. The frame format is set by three inputs:
- a 9-bit-field select;
- a parity enable;
- an odd/even parity select.

The received field is returned with a one-cycle valid strobe. Parity, noise and framing flags come with it and hold until the next strobe. A parity interrupt request is the parity flag gated by an enable input.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, rx_valid, par_err, noise_err, frame_err and par_irq are 0 and rx_word is all zeros.
- R2: Within a bit, the tick that follows the bit's start is sample 1. The bit value is the majority of samples 8, 9 and 10.
- R3: noise_err is reported as 1 for a frame when, in any voted bit of that frame (start, field or stop), samples 8, 9 and 10 are not all equal. A bit that is noisy still takes its majority value.
- R4: A falling edge on the synchronized line while idle restarts the sample count from zero. This holds even when the edge comes right after sample 10 of the previous stop bit.
- R5: If the start bit votes 1, the frame is dropped. In that case no rx_valid pulse is produced and rx_word and all flags keep their previous values.
- R6: The field is sent least significant bit first. It is 8 bits long into rx_word[7:0] with rx_word[8]=0 when cfg_nine_bit=0, and 9 bits long into rx_word[8:0] when cfg_nine_bit=1. With parity enabled, the parity bit is the last field bit (bit 7 or bit 8) and stays in rx_word.
- R7: With cfg_par_en=1, par_err is 1 when the number of ones in the whole field is odd (cfg_par_odd=0) or even (cfg_par_odd=1). With cfg_par_en=0, par_err is 0.
- R8: par_irq is 1 exactly while par_err=1 and par_irq_en=1.
- R9: A stop bit that votes 0 sets frame_err. rx_valid still pulses for that frame.
- R10: rx_valid is a one-cycle pulse after sample 10 of the stop bit. rx_word and the flags change only together with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_nine_bit | input | 1 | 1 selects a 9-bit field, 0 an 8-bit field |
| cfg_par_en | input | 1 | Enable the parity check on the last field bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even parity |
| par_irq_en | input | 1 | Parity interrupt enable |
| rx_word | output | 9 | Last received field |
| rx_valid | output | 1 | One-cycle strobe for a new frame |
| par_err | output | 1 | Parity error of the last frame |
| noise_err | output | 1 | Sample disagreement in the last frame |
| frame_err | output | 1 | Stop bit voted low in the last frame |
| par_irq | output | 1 | Parity interrupt request |

## Verification
Several checks of one frame land on the same stop-bit vote, and so on the same valid strobe:
- the parity check;
- the framing check;
- the noise check.

The bench sends one frame with wrong parity, a low stop bit and a noisy stop sample. It expects all three flags together on that single strobe, with the word still correct.

A second case sends a new start edge right after the stop vote of the previous frame, so that frame completion and restart follow each other directly. The bench then expects both words to be intact.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
  } rx_cfg_t;

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_s,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= rx_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rx_s = chain_q[STAGES-1];
  assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler #(
  parameter int OS_RATE    = 16,
  parameter int VOTE_FIRST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic rx_s,
  input  logic restart,
  input  logic run,
  output logic vote_valid,
  output logic vote_bit,
  output logic vote_noise
);

  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] IDX_A    = CNT_W'(VOTE_FIRST - 1);
  localparam logic [CNT_W-1:0] IDX_B    = CNT_W'(VOTE_FIRST);
  localparam logic [CNT_W-1:0] IDX_C    = CNT_W'(VOTE_FIRST + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             smp_a_q, smp_a_d;
  logic             smp_b_q, smp_b_d;
  logic             step;

  assign step = run & os_tick;

  always_comb begin
    cnt_d   = cnt_q;
    smp_a_d = smp_a_q;
    smp_b_d = smp_b_q;
    if (restart) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
      if (cnt_q == IDX_A) smp_a_d = rx_s;
      if (cnt_q == IDX_B) smp_b_d = rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      smp_a_q <= smp_a_d;
      smp_b_q <= smp_b_d;
    end
  end

  assign vote_valid = step & (cnt_q == IDX_C);
  assign vote_bit   = (smp_a_q & smp_b_q) | (smp_a_q & rx_s) | (smp_b_q & rx_s);
  assign vote_noise = ~((smp_a_q == smp_b_q) & (smp_b_q == rx_s));

  // R4: a restart always realigns the sample count to zero
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              vote_valid,
  input  logic              vote_bit,
  input  logic              vote_noise,
  input  rx_cfg_t           cfg_in,
  output logic              restart,
  output logic              run,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              par_err,
  output logic              noise_err,
  output logic              frame_err
);

  localparam int IDX_W = $clog2(WORD_W + 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(WORD_W - 2);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              nacc_q, nacc_d;
  rx_cfg_t           cfg_q, cfg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              pe_q, pe_d, ne_q, ne_d, fe_q, fe_d, valid_q, valid_d;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx = cfg_q.nine ? LAST_LONG : LAST_SHORT;

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    nacc_d    = nacc_q;
    cfg_d     = cfg_q;
    word_d    = word_q;
    pe_d      = pe_q;
    ne_d      = ne_q;
    fe_d      = fe_q;
    valid_d   = 1'b0;
    restart   = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (fall) begin
          restart   = 1'b1;
          state_d   = RX_START;
          cfg_d     = cfg_in;
          bit_cnt_d = '0;
          shreg_d   = '0;
          nacc_d    = 1'b0;
        end
      end
      RX_START: begin
        if (vote_valid) begin
          if (vote_bit) begin
            state_d = RX_IDLE;
          end else begin
            nacc_d  = vote_noise;
            state_d = RX_DATA;
          end
        end
      end
      RX_DATA: begin
        if (vote_valid) begin
          for (int i = 0; i < WORD_W; i++) begin
            if (i == int'(bit_cnt_q)) shreg_d[i] = vote_bit;
          end
          nacc_d    = nacc_q | vote_noise;
          bit_cnt_d = bit_cnt_q + IDX_W'(1);
          if (bit_cnt_q == last_idx) state_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (vote_valid) begin
          valid_d = 1'b1;
          word_d  = shreg_q;
          pe_d    = cfg_q.par_en & ((^shreg_q) ^ cfg_q.par_odd);
          ne_d    = nacc_q | vote_noise;
          fe_d    = ~vote_bit;
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      nacc_q    <= 1'b0;
      cfg_q     <= '0;
      word_q    <= '0;
      pe_q      <= 1'b0;
      ne_q      <= 1'b0;
      fe_q      <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      nacc_q    <= nacc_d;
      cfg_q     <= cfg_d;
      word_q    <= word_d;
      pe_q      <= pe_d;
      ne_q      <= ne_d;
      fe_q      <= fe_d;
      valid_q   <= valid_d;
    end
  end

  assign run       = (state_q != RX_IDLE);
  assign rx_word   = word_q;
  assign rx_valid  = valid_q;
  assign par_err   = pe_q;
  assign noise_err = ne_q;
  assign frame_err = fe_q;

  // R10: the valid strobe lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: results only move together with the strobe
  p_hold_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable({word_q, pe_q, ne_q, fe_q}));

  // R5: a start bit voted high returns to idle without a strobe
  p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && vote_valid && vote_bit) |=> (state_q == RX_IDLE && !rx_valid));

  // R7: no parity error reported for a frame taken without parity
  p_par_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_q.par_en) |-> !par_err);

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int VOTE_FIRST  = 8,
  parameter int WORD_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              cfg_nine_bit,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              par_irq_en,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              par_err,
  output logic              noise_err,
  output logic              frame_err,
  output logic              par_irq
);

  logic    rst_meta_q, rst_sync_q;
  logic    rx_s, fall, restart, run;
  logic    vote_valid, vote_bit, vote_noise;
  rx_cfg_t cfg_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign cfg_in = '{nine: cfg_nine_bit, par_en: cfg_par_en, par_odd: cfg_par_odd};

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .rx_in (rx_in),
    .rx_s  (rx_s),
    .fall  (fall)
  );

  uart_os_rx_sampler #(.OS_RATE(OS_RATE), .VOTE_FIRST(VOTE_FIRST)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .os_tick    (os_tick),
    .rx_s       (rx_s),
    .restart    (restart),
    .run        (run),
    .vote_valid (vote_valid),
    .vote_bit   (vote_bit),
    .vote_noise (vote_noise)
  );

  uart_os_rx_frame #(.WORD_W(WORD_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .fall       (fall),
    .vote_valid (vote_valid),
    .vote_bit   (vote_bit),
    .vote_noise (vote_noise),
    .cfg_in     (cfg_in),
    .restart    (restart),
    .run        (run),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid),
    .par_err    (par_err),
    .noise_err  (noise_err),
    .frame_err  (frame_err)
  );

  assign par_irq = par_err & par_irq_en;

endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       cfg_nine_bit = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       par_irq_en = 1'b0;
  logic [8:0] rx_word;
  logic       rx_valid, par_err, noise_err, frame_err, par_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int n_valid  = 0;

  always #5 clk = ~clk;

  uart_os_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .os_tick      (os_tick),
    .rx_in        (rx_in),
    .cfg_nine_bit (cfg_nine_bit),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .par_irq_en   (par_irq_en),
    .rx_word      (rx_word),
    .rx_valid     (rx_valid),
    .par_err      (par_err),
    .noise_err    (noise_err),
    .frame_err    (frame_err),
    .par_irq      (par_irq)
  );

  always @(negedge clk) if (rx_valid) n_valid++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one oversampling slot: drive the line, then one tick
  task automatic slot(input logic v);
    rx_in = v;
    repeat (3) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  // one bit: pattern bit s-1 is the value of sample s
  task automatic send_bit(input logic [15:0] pat, input int nslots);
    for (int s = 0; s < nslots; s++) slot(pat[s]);
  endtask

  task automatic send_frame(input logic [8:0] field, input int nbits, input logic stop,
                            input int noisy_bit, input int stop_len);
    logic [15:0] pat;
    pat = 16'h0000;
    if (noisy_bit == 0) pat[7] = 1'b1;
    send_bit(pat, 16);
    for (int b = 0; b < nbits; b++) begin
      pat = {16{field[b]}};
      if (noisy_bit == b + 1) pat[7] = ~field[b];
      send_bit(pat, 16);
    end
    pat = {16{stop}};
    if (noisy_bit == nbits + 1) pat[8] = ~stop;
    send_bit(pat, stop_len);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  // send a frame and check the strobe count, the word and the flags
  task automatic frame_check(input string req, input logic [8:0] field, input int nbits,
                             input logic stop, input int noisy, input int stop_len,
                             input logic [8:0] exp_word, input logic exp_pe,
                             input logic exp_ne, input logic exp_fe);
    int v0;
    v0 = n_valid;
    send_frame(field, nbits, stop, noisy, stop_len);
    #1;
    check({req, " valid count"}, 16'(n_valid - v0), 16'd1);
    check({req, " word"}, {7'd0, rx_word}, {7'd0, exp_word});
    check({req, " par_err"}, {15'd0, par_err}, {15'd0, exp_pe});
    check({req, " noise_err"}, {15'd0, noise_err}, {15'd0, exp_ne});
    check({req, " frame_err"}, {15'd0, frame_err}, {15'd0, exp_fe});
  endtask

  function automatic logic par_of(input logic [8:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic t_reset();
    check("R1 rx_valid", {15'd0, rx_valid}, 16'd0);
    check("R1 rx_word", {7'd0, rx_word}, 16'd0);
    check("R1 flags", {13'd0, par_err, noise_err, frame_err}, 16'd0);
    check("R1 par_irq", {15'd0, par_irq}, 16'd0);
  endtask

  task automatic t_plain();
    cfg_nine_bit = 1'b0; cfg_par_en = 1'b0;
    frame_check("R6 R2 8-bit", 9'h0A5, 8, 1'b1, -1, 16, 9'h0A5, 1'b0, 1'b0, 1'b0);
    idle(5);
    cfg_nine_bit = 1'b1;
    frame_check("R6 R2 9-bit", 9'h13C, 9, 1'b1, -1, 16, 9'h13C, 1'b0, 1'b0, 1'b0);
    idle(3);
  endtask

  task automatic t_parity();
    logic [8:0] f;
    cfg_nine_bit = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; par_irq_en = 1'b1;
    f = {2'b00, par_of(9'h035, 1'b0), 6'h35} & 9'h0FF;
    f = {1'b0, par_of({2'b0, 7'h35}, 1'b0), 7'h35};
    frame_check("R7 even ok", f, 8, 1'b1, -1, 16, f, 1'b0, 1'b0, 1'b0);
    check("R8 irq low", {15'd0, par_irq}, 16'd0);
    idle(2);
    cfg_par_odd = 1'b1;
    frame_check("R7 odd bad", f, 8, 1'b1, -1, 16, f, 1'b1, 1'b0, 1'b0);
    check("R8 irq on", {15'd0, par_irq}, 16'd1);
    par_irq_en = 1'b0;
    #1;
    check("R8 irq gated", {15'd0, par_irq}, 16'd0);
    idle(2);
    cfg_nine_bit = 1'b1;
    f = {par_of({1'b0, 8'hC3}, 1'b1), 8'hC3};
    frame_check("R7 9-bit odd ok", f, 9, 1'b1, -1, 16, f, 1'b0, 1'b0, 1'b0);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    idle(2);
  endtask

  task automatic t_noise();
    cfg_nine_bit = 1'b0;
    frame_check("R3 R2 noisy data", 9'h05A, 8, 1'b1, 4, 16, 9'h05A, 1'b0, 1'b1, 1'b0);
    idle(2);
    frame_check("R3 clean clears", 9'h081, 8, 1'b1, -1, 16, 9'h081, 1'b0, 1'b0, 1'b0);
    idle(2);
    frame_check("R3 noisy start", 9'h0F0, 8, 1'b1, 0, 16, 9'h0F0, 1'b0, 1'b1, 1'b0);
    idle(2);
  endtask

  task automatic t_false_start();
    int v0;
    v0 = n_valid;
    send_bit(16'hFFF8, 16);
    idle(20);
    #1;
    check("R5 no strobe", 16'(n_valid - v0), 16'd0);
    check("R5 word kept", {7'd0, rx_word}, 16'h0F0);
    check("R5 noise kept", {15'd0, noise_err}, 16'd1);
    frame_check("R5 recover", 9'h033, 8, 1'b1, -1, 16, 9'h033, 1'b0, 1'b0, 1'b0);
    idle(2);
  endtask

  task automatic t_combined();
    logic [8:0] f;
    cfg_nine_bit = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; par_irq_en = 1'b1;
    f = {1'b0, ~par_of({2'b0, 7'h11}, 1'b0), 7'h11};
    frame_check("R9 R7 R3 same strobe", f, 8, 1'b0, 9, 16, f, 1'b1, 1'b1, 1'b1);
    check("R8 irq combined", {15'd0, par_irq}, 16'd1);
    cfg_par_en = 1'b0; par_irq_en = 1'b0;
    idle(4);
  endtask

  task automatic t_realign();
    cfg_nine_bit = 1'b0;
    frame_check("R4 short stop A", 9'h0C6, 8, 1'b1, -1, 10, 9'h0C6, 1'b0, 1'b0, 1'b0);
    frame_check("R4 back to back B", 9'h019, 8, 1'b1, -1, 16, 9'h019, 1'b0, 1'b0, 1'b0);
    idle(7);
    frame_check("R4 after gap", 9'h0FE, 8, 1'b1, -1, 16, 9'h0FE, 1'b0, 1'b0, 1'b0);
    idle(3);
    #1;
    check("R10 held", {7'd0, rx_word}, 16'h0FE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    idle(4);
    t_plain();
    t_parity();
    t_noise();
    t_false_start();
    t_combined();
    t_realign();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule